// File: doc/BRIEF.md
# OSD-over-video pixel blender

This block lays one on-screen-display layer over a video layer. Each cycle it may take one pixel from each layer. The video pixel arrives as YCbCr. The display pixel arrives as a bitmap value of 1, 2, 4 or 8 bits, together with a flag that says whether the pixel lies inside the display window. The bitmap value is turned into a colour address, either directly or through a 16-entry remap table. That address reads either a fixed colour table or a 256-entry colour RAM. The colour is then mixed with the video pixel using a weight in eighths. A colour key can make selected bitmap values fully transparent.

Software sets the window controls, the remap table and the colour RAM through a 16-bit write-only register port. The pixel stream uses valid/ready on both sides. The pipeline has two register stages and no buffering, so input ready is output ready. When the downstream side holds off, the whole pipeline freezes and every stage keeps its contents.

Top module: `osd_blend`

## Requirements
- R1: After reset, m_valid is low and the window is disabled (control word 0). Remap entry i holds the value i.
- R2: s_ready equals m_ready in every cycle. While m_ready is low no stage advances, and m_valid and m_pix keep their values.
- R3: A pixel accepted on a rising edge appears on m_pix, with m_valid high, after the next rising edge on which m_ready is high. m_valid never rises without an accepted pixel.
- R4: When s_in_win is low, or the enable bit (control bit 0) is clear, m_pix equals s_vid exactly. Pixels are packed as Y in bits 23:16, Cb in bits 15:8 and Cr in bits 7:0.
- R5: The depth field (control bits 2:1) selects the bitmap depth: 0 = 1 bit, 1 = 2 bits, 2 = 4 bits, 3 = 8 bits. Only the low 1, 2, 4 or 8 bits of s_idx form the pixel value. The higher bits have no effect.
- R6: Below 8 bits per pixel, the pixel value selects a remap entry, and the 8-bit content of that entry is the colour address. At 8 bits per pixel the pixel value is the colour address and the remap table is not used. A write to register 3 sets remap entry data[11:8] to data[7:0].
- R7: Control bit 7 selects the colour table. When it is 0, the fixed table is used, where entry a has Y = a, Cb = 255 - a and Cr = a XOR 0x5A. When it is 1, the colour RAM is used.
- R8: A write to register 1 only stages Y (data[15:8]) and Cb (data[7:0]) and changes no RAM entry. A write to register 2 stores the staged Y and Cb with Cr = data[15:8] into the RAM entry at address data[7:0].
- R9: The blend code (control bits 5:3) c in 0..6 gives an OSD weight w = c. Each component is computed as (osd*w + vid*(8-w)) >> 3 and truncated to 8 bits.
- R10: Blend code 7 gives weight 8/8, so m_pix equals the table colour. A weight of 7/8 cannot be selected.
- R11: When control bit 6 (key enable) is set and the pixel value after depth masking equals the key (control bits 15:8), m_pix equals s_vid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe, one write per cycle |
| cfg_addr | input | 2 | Register select: 0 control, 1 colour stage, 2 colour commit, 3 remap |
| cfg_wdata | input | 16 | Register write data |
| s_valid | input | 1 | Input pixel valid |
| s_ready | output | 1 | Input pixel accepted when high with s_valid |
| s_in_win | input | 1 | Pixel lies inside the display window |
| s_idx | input | 8 | Display bitmap value |
| s_vid | input | 24 | Video pixel {Y, Cb, Cr} |
| m_valid | output | 1 | Output pixel valid |
| m_ready | input | 1 | Downstream accepts output pixel |
| m_pix | output | 24 | Blended pixel {Y, Cb, Cr} |

## Verification
The assertions check the stream rules on every cycle. Ready must track downstream ready, the output must hold while stalled, output valid must follow an accepted pixel by two advancing cycles, and a pixel outside the window must come out bit-exact. Only the bench scenarios can show the colour path. That path covers the arithmetic of each blend code, the depth masking and remap lookup, the two-word commit of the colour RAM, the choice between the two tables, and key transparency. Each of these is checked against a model that the bench builds from the register encodings.

// File: rtl/osd_blend_pkg.sv
`timescale 1ns/1ps
package osd_blend_pkg;
  localparam int COMP_W  = 8;
  localparam int IDX_W   = 8;
  localparam int CLUT_N  = 1 << IDX_W;
  localparam int REMAP_W = 4;
  localparam int REMAP_N = 1 << REMAP_W;
  localparam int FRAC    = 3;
  localparam int WGT_W   = FRAC + 1;
  localparam int PIX_W   = 3 * COMP_W;

  typedef struct packed {
    logic [COMP_W-1:0] y;
    logic [COMP_W-1:0] cb;
    logic [COMP_W-1:0] cr;
  } ycc_t;

  typedef enum logic [1:0] {
    DEPTH_1 = 2'd0,
    DEPTH_2 = 2'd1,
    DEPTH_4 = 2'd2,
    DEPTH_8 = 2'd3
  } depth_e;

  // Layout of the 16-bit control register, MSB first
  typedef struct packed {
    logic [IDX_W-1:0] key;
    logic             ram_sel;
    logic             key_en;
    logic [2:0]       code;
    depth_e           depth;
    logic             en;
  } win_ctl_t;

  localparam logic [1:0] REG_CTL    = 2'd0;
  localparam logic [1:0] REG_STAGE  = 2'd1;
  localparam logic [1:0] REG_COMMIT = 2'd2;
  localparam logic [1:0] REG_REMAP  = 2'd3;

  function automatic ycc_t rom_colour(input logic [IDX_W-1:0] a);
    ycc_t r;
    r.y  = a;
    r.cb = ~a;
    r.cr = a ^ 8'h5A;
    return r;
  endfunction

  // code 7 jumps to full weight; 7/8 is not reachable
  function automatic logic [WGT_W-1:0] code_to_weight(input logic [2:0] c);
    return (c == 3'd7) ? WGT_W'(1 << FRAC) : WGT_W'(c);
  endfunction

  function automatic logic [IDX_W-1:0] depth_mask(input logic [IDX_W-1:0] v,
                                                   input depth_e d);
    case (d)
      DEPTH_1: return v & IDX_W'(1);
      DEPTH_2: return v & IDX_W'(3);
      DEPTH_4: return v & IDX_W'(15);
      default: return v;
    endcase
  endfunction
endpackage

// File: rtl/osd_blend_cfg.sv
`timescale 1ns/1ps
module osd_blend_cfg
  import osd_blend_pkg::*;
(
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             we,
  input  logic [1:0]                       addr,
  input  logic [15:0]                      wdata,
  output win_ctl_t                         ctl,
  output logic                             clut_we,
  output logic [IDX_W-1:0]                 clut_waddr,
  output ycc_t                             clut_wdata,
  output logic [REMAP_N-1:0][IDX_W-1:0]    remap
);
  win_ctl_t          ctl_q;
  logic [COMP_W-1:0] stage_y_q;
  logic [COMP_W-1:0] stage_cb_q;
  logic [IDX_W-1:0]  remap_q [REMAP_N];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q      <= '0;
      stage_y_q  <= '0;
      stage_cb_q <= '0;
    end else if (we) begin
      if (addr == REG_CTL)
        ctl_q <= win_ctl_t'(wdata);
      if (addr == REG_STAGE) begin
        stage_y_q  <= wdata[15:8];
        stage_cb_q <= wdata[7:0];
      end
    end
  end

  for (genvar i = 0; i < REMAP_N; i++) begin : g_remap
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        remap_q[i] <= IDX_W'(i);
      else if (we && addr == REG_REMAP && wdata[8 +: REMAP_W] == REMAP_W'(i))
        remap_q[i] <= wdata[7:0];
    end
    assign remap[i] = remap_q[i];
  end

  assign ctl        = ctl_q;
  assign clut_we    = we && (addr == REG_COMMIT);
  assign clut_waddr = wdata[7:0];
  assign clut_wdata = '{y: stage_y_q, cb: stage_cb_q, cr: wdata[15:8]};
endmodule

// File: rtl/osd_blend_clut.sv
`timescale 1ns/1ps
module osd_blend_clut
  import osd_blend_pkg::*;
(
  input  logic             clk,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_addr,
  input  logic             rd_ram_sel,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  ycc_t             wdata,
  output ycc_t             q
);
  ycc_t mem [CLUT_N];
  ycc_t ram_q;
  ycc_t rom_q;
  logic sel_q;

  always_ff @(posedge clk) begin
    if (we)
      mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rd_en) begin
      ram_q <= mem[rd_addr];
      rom_q <= rom_colour(rd_addr);
      sel_q <= rd_ram_sel;
    end
  end

  assign q = sel_q ? ram_q : rom_q;
endmodule

// File: rtl/osd_blend_mix.sv
`timescale 1ns/1ps
module osd_blend_mix
  import osd_blend_pkg::*;
(
  input  ycc_t             osd,
  input  ycc_t             vid,
  input  logic [WGT_W-1:0] w,
  output ycc_t             res
);
  localparam int PW = COMP_W + WGT_W;
  localparam logic [WGT_W-1:0] FULL = WGT_W'(1 << FRAC);

  logic [2:0][COMP_W-1:0] o_a, v_a, r_a;
  assign o_a = osd;
  assign v_a = vid;

  for (genvar c = 0; c < 3; c++) begin : g_comp
    logic [PW-1:0] sum;
    assign sum = PW'(o_a[c]) * PW'(w) + PW'(v_a[c]) * PW'(FULL - w);
    assign r_a[c] = sum[FRAC +: COMP_W];
  end

  assign res = r_a;
endmodule

// File: rtl/osd_blend.sv
`timescale 1ns/1ps
module osd_blend
  import osd_blend_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [15:0]       cfg_wdata,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic              s_in_win,
  input  logic [IDX_W-1:0]  s_idx,
  input  logic [PIX_W-1:0]  s_vid,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [PIX_W-1:0]  m_pix
);
  win_ctl_t                       ctl;
  logic                           clut_we;
  logic [IDX_W-1:0]               clut_waddr;
  ycc_t                           clut_wdata;
  logic [REMAP_N-1:0][IDX_W-1:0]  remap;

  osd_blend_cfg u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .we         (cfg_we),
    .addr       (cfg_addr),
    .wdata      (cfg_wdata),
    .ctl        (ctl),
    .clut_we    (clut_we),
    .clut_waddr (clut_waddr),
    .clut_wdata (clut_wdata),
    .remap      (remap)
  );

  // stage 0: index masking, remap, key and weight selection
  logic             adv;
  logic [IDX_W-1:0] pix_val;
  logic [IDX_W-1:0] look_addr;
  logic             key_hit;
  logic [WGT_W-1:0] w0;

  assign adv       = m_ready;
  assign s_ready   = m_ready;
  assign pix_val   = depth_mask(s_idx, ctl.depth);
  assign look_addr = (ctl.depth == DEPTH_8) ? pix_val : remap[pix_val[REMAP_W-1:0]];
  assign key_hit   = ctl.key_en && (pix_val == ctl.key);
  assign w0        = (!ctl.en || !s_in_win || key_hit) ? '0 : code_to_weight(ctl.code);

  // stage 1: colour read and aligned video
  ycc_t             colour1;
  logic             v1;
  ycc_t             vid1;
  logic [WGT_W-1:0] w1;

  osd_blend_clut u_clut (
    .clk        (clk),
    .rd_en      (adv),
    .rd_addr    (look_addr),
    .rd_ram_sel (ctl.ram_sel),
    .we         (clut_we),
    .waddr      (clut_waddr),
    .wdata      (clut_wdata),
    .q          (colour1)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1   <= 1'b0;
      vid1 <= '0;
      w1   <= '0;
    end else if (adv) begin
      v1   <= s_valid;
      vid1 <= ycc_t'(s_vid);
      w1   <= w0;
    end
  end

  // stage 2: blend and output register
  ycc_t mixed;

  osd_blend_mix u_mix (
    .osd (colour1),
    .vid (vid1),
    .w   (w1),
    .res (mixed)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_pix   <= '0;
    end else if (adv) begin
      m_valid <= v1;
      m_pix   <= mixed;
    end
  end
endmodule

// File: rtl/osd_blend_chk.sv
`timescale 1ns/1ps
module osd_blend_chk
  import osd_blend_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             s_valid,
  input logic             s_ready,
  input logic             s_in_win,
  input logic [PIX_W-1:0] s_vid,
  input logic             m_valid,
  input logic             m_ready,
  input logic [PIX_W-1:0] m_pix
);
  a_r2_ready_follows: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready == m_ready);

  a_r2_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_pix)));

  a_r3_two_stage: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready ##1 m_ready) |=> m_valid);

  a_r3_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    (s_ready && !s_valid ##1 m_ready) |=> !m_valid);

  a_r4_outside_window: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready && !s_in_win ##1 m_ready) |=> (m_pix == $past(s_vid, 2)));
endmodule

bind osd_blend osd_blend_chk u_chk (.*);

// File: tb/osd_blend_bench.sv
`timescale 1ns/1ps
module osd_blend_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic        s_in_win = 1'b0;
  logic [7:0]  s_idx = '0;
  logic [23:0] s_vid = '0;
  logic        m_valid;
  logic        m_ready;
  logic [23:0] m_pix;

  int checks = 0;
  int errors = 0;
  int rdy_mode = 0;
  logic patt = 1'b1;

  always #2.5 clk = ~clk;

  assign m_ready = (rdy_mode == 0) || (rdy_mode == 1 && patt);

  osd_blend u_osd_blend (.*);

  // bench mirror of the programmed state
  logic        b_en = 0, b_key_en = 0, b_tsel = 0;
  logic [1:0]  b_depth = 0;
  logic [2:0]  b_code = 0;
  logic [7:0]  b_key = 0;
  logic [7:0]  b_sy = 0, b_scb = 0;
  logic [23:0] b_ram [256];
  logic [7:0]  b_remap [16];

  logic [23:0] exp_q[$];
  string       tag_q[$];
  string       cur_tag = "R1";

  function automatic logic [23:0] rom_model(input logic [7:0] a);
    return {a, 8'(255 - a), a ^ 8'h5A};
  endfunction

  function automatic logic [23:0] model(input logic inw, input logic [7:0] idx,
                                       input logic [23:0] vid);
    logic [7:0]  pv, ad;
    logic [23:0] col, r;
    int w;
    case (b_depth)
      2'd0: pv = idx & 8'h01;
      2'd1: pv = idx & 8'h03;
      2'd2: pv = idx & 8'h0F;
      default: pv = idx;
    endcase
    if (!b_en || !inw) return vid;
    if (b_key_en && pv == b_key) return vid;
    ad  = (b_depth == 2'd3) ? pv : b_remap[pv[3:0]];
    col = b_tsel ? b_ram[ad] : rom_model(ad);
    w   = (b_code == 3'd7) ? 8 : int'(b_code);
    for (int k = 0; k < 3; k++) begin
      int s;
      s = int'(col[k*8 +: 8]) * w + int'(vid[k*8 +: 8]) * (8 - w);
      r[k*8 +: 8] = 8'(s >> 3);
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [23:0] got, input logic [23:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", req, got, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] a, input logic [15:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic set_ctl(input logic en, input logic [1:0] depth, input logic [2:0] code,
                         input logic key_en, input logic tsel, input logic [7:0] key);
    b_en = en; b_depth = depth; b_code = code; b_key_en = key_en; b_tsel = tsel; b_key = key;
    cfg_write(2'd0, {key, tsel, key_en, code, depth, en});
  endtask

  task automatic ram_write(input logic [7:0] a, input logic [23:0] ycc);
    b_sy = ycc[23:16]; b_scb = ycc[15:8];
    cfg_write(2'd1, ycc[23:8]);
    b_ram[a] = ycc;
    cfg_write(2'd2, {ycc[7:0], a});
  endtask

  task automatic remap_write(input logic [3:0] i, input logic [7:0] v);
    b_remap[i] = v;
    cfg_write(2'd3, {4'h0, i, v});
  endtask

  task automatic send(input logic inw, input logic [7:0] idx, input logic [23:0] vid);
    logic [23:0] e;
    e = model(inw, idx, vid);
    s_valid = 1'b1; s_in_win = inw; s_idx = idx; s_vid = vid;
    do @(posedge clk); while (!s_ready);
    exp_q.push_back(e);
    tag_q.push_back(cur_tag);
    #1 s_valid = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(posedge clk);
    @(posedge clk); #1;
  endtask

  // ready pattern, changed away from the active edge
  initial forever begin
    @(posedge clk); #1;
    patt = ($urandom_range(0, 3) != 0);
  end

  // monitor / scoreboard
  initial forever begin
    @(negedge clk);
    if (rst_n && m_valid && m_ready) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R3 unexpected output got %h exp none", m_pix);
      end else begin
        logic [23:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, m_pix, e);
      end
    end
  end

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #1000000;
    checks++; errors++;
    $display("FAIL R3 watchdog expired got pending %0d exp 0", exp_q.size());
    finish_run();
  end

  initial begin
    for (int i = 0; i < 16; i++) b_remap[i] = 8'(i);
    for (int i = 0; i < 256; i++) b_ram[i] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R1", {23'b0, m_valid}, 24'h0);
    check("R2", {23'b0, s_ready}, 24'h1);
    @(posedge clk); #1;

    // R1: default control leaves the window disabled
    cur_tag = "R1";
    send(1'b1, 8'h42, 24'h123456);
    drain();

    // R3: latency through two register stages
    send(1'b1, 8'h11, 24'hABCDEF);
    @(negedge clk);
    check("R3", {23'b0, m_valid}, 24'h0);
    @(negedge clk);
    check("R3", {23'b0, m_valid}, 24'h1);
    drain();

    // R10 / R7: fixed table, full opacity
    set_ctl(1, 2'd3, 3'd7, 0, 0, 8'h00);
    cur_tag = "R10";
    send(1'b1, 8'h00, 24'h808080);
    send(1'b1, 8'h37, 24'h101010);
    send(1'b1, 8'hFF, 24'hFFFFFF);
    drain();

    // R9: fractional weights
    cur_tag = "R9";
    for (int c = 0; c < 7; c++) begin
      set_ctl(1, 2'd3, 3'(c), 0, 0, 8'h00);
      send(1'b1, 8'hC3, 24'h20E07F);
      send(1'b1, 8'h0F, 24'hFF00FF);
      drain();
    end

    // R4: outside the window
    set_ctl(1, 2'd3, 3'd7, 0, 0, 8'h00);
    cur_tag = "R4";
    send(1'b0, 8'h55, 24'h0A0B0C);
    send(1'b0, 8'hAA, 24'hFEDCBA);
    drain();

    // R8: colour RAM two-word write
    ram_write(8'h10, 24'h112233);
    ram_write(8'h20, 24'h445566);
    ram_write(8'hAB, 24'hF0E1D2);
    set_ctl(1, 2'd3, 3'd7, 0, 1, 8'h00);
    cur_tag = "R8";
    send(1'b1, 8'h10, 24'h000000);
    send(1'b1, 8'h20, 24'h000000);
    send(1'b1, 8'hAB, 24'h000000);
    drain();
    b_sy = 8'h99; b_scb = 8'h88;
    cfg_write(2'd1, 16'h9988);
    send(1'b1, 8'h10, 24'h000000);
    drain();
    b_ram[8'h10] = {b_sy, b_scb, 8'h77};
    cfg_write(2'd2, {8'h77, 8'h10});
    send(1'b1, 8'h10, 24'h000000);
    drain();

    // R7: same address through the fixed table
    set_ctl(1, 2'd3, 3'd7, 0, 0, 8'h00);
    cur_tag = "R7";
    send(1'b1, 8'h10, 24'h000000);
    drain();

    // R5 / R6: depth masking and remap
    remap_write(4'd0, 8'h20);
    remap_write(4'd1, 8'h20);
    remap_write(4'd2, 8'hAB);
    remap_write(4'd3, 8'h10);
    set_ctl(1, 2'd1, 3'd7, 0, 1, 8'h00);
    cur_tag = "R5";
    send(1'b1, 8'hF1, 24'h000000);
    send(1'b1, 8'h7E, 24'h000000);
    set_ctl(1, 2'd0, 3'd7, 0, 1, 8'h00);
    send(1'b1, 8'hFE, 24'h000000);
    drain();
    cur_tag = "R6";
    set_ctl(1, 2'd2, 3'd7, 0, 0, 8'h00);
    send(1'b1, 8'h23, 24'h000000);
    send(1'b1, 8'h0C, 24'h000000);
    set_ctl(1, 2'd3, 3'd7, 0, 0, 8'h00);
    send(1'b1, 8'h02, 24'h000000);
    drain();

    // R11: colour key
    set_ctl(1, 2'd2, 3'd7, 1, 0, 8'h05);
    cur_tag = "R11";
    send(1'b1, 8'h05, 24'h314159);
    send(1'b1, 8'h35, 24'h271828);
    send(1'b1, 8'h06, 24'h161803);
    drain();

    // R2: stall holds the output
    set_ctl(1, 2'd3, 3'd4, 0, 0, 8'h00);
    cur_tag = "R2";
    send(1'b1, 8'h9C, 24'h5A5A5A);
    @(posedge clk); #1;
    rdy_mode = 2;
    begin
      logic [23:0] held;
      @(negedge clk);
      held = m_pix;
      check("R2", {22'b0, m_valid, s_ready}, 24'h2);
      for (int i = 0; i < 3; i++) begin
        @(negedge clk);
        check("R2", m_pix, held);
        check("R2", {22'b0, m_valid, s_ready}, 24'h2);
      end
    end
    @(posedge clk); #1;
    rdy_mode = 0;
    drain();

    // R2 / R9: stream under random back-pressure
    rdy_mode = 1;
    set_ctl(1, 2'd3, 3'd3, 0, 0, 8'h00);
    for (int i = 0; i < 300; i++)
      send(1'($urandom_range(0, 1)), 8'($urandom), 24'($urandom));
    drain();
    rdy_mode = 0;
    drain();

    check("R3", 24'(exp_q.size()), 24'h0);
    finish_run();
  end
endmodule